// File: doc/BRIEF.md
# Multicycle Shared-ALU Datapath

This block is the datapath of a 32-bit load/store core that spends several clocks on each instruction. One ALU does every calculation in turn: it advances the program counter by four, forms the branch destination, adds a base register to an offset, and produces the result of register and immediate arithmetic. One memory holds both code and data. It has a combinational read port and a write port that updates on the clock edge.

The datapath holds the program counter, an instruction register, a 32-entry by 32-bit register file, a branch destination register and an immediate extender. It also holds the multiplexers in front of and behind the ALU. No sequencing logic sits inside the block. Every steering and enable signal is an input port, driven cycle by cycle by an external state machine or by the testbench. A typical instruction passes through these steps, one per clock:
- fetch
- decode, which also computes the branch destination
- execute or address calculation
- memory access or write-back

There is no register for fetched data. During a load's write-back step the memory address select must therefore stay on the ALU result.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, instruction register and branch destination register all become zero (synchronous, active-high).
- R2: ALU operand A is the program counter when `a_sel`=0 and register read port A (field rs, bits 25:21) when `a_sel`=1. The 2-bit `b_sel` picks operand B: 0 gives the constant 4, 1 gives register read port B (field rt, bits 20:16), 2 gives the extended immediate shifted left by two, and 3 gives the extended immediate unshifted.
- R3: The 16-bit immediate (bits 15:0) is sign-extended when `ext_sign`=1 and zero-extended when `ext_sign`=0.
- R4: `alu_op` encodes 0=add, 1=subtract (A minus B), 2=bitwise OR, and 3=function-field decode. Function-field decode uses bits 5:0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A signed set-less-than (result 1 or 0). Any other function code gives 0.
- R5: `zero_o` is 1 exactly when the 32-bit ALU result is zero.
- R6: The program counter is written at a rising edge when `pc_wr`=1, or when `pc_wr_cond`=1 and `zero_o`=1. Otherwise it holds. The value written is the ALU result when `pc_src`=0 and the branch destination register when `pc_src`=1.
- R7: The branch destination register loads the ALU result at a rising edge when `tgt_wr`=1 and holds otherwise.
- R8: The instruction register loads the memory read data at a rising edge only when `ir_wr`=1 and holds otherwise.
- R9: The memory read address is the program counter when `addr_sel`=0 and the ALU result when `addr_sel`=1. The read is combinational. When `mem_wr`=1, register read port B is written at the ALU-result address on the rising edge. Memory is word addressed by address bits above bit 1.
- R10: When `rf_wr`=1, the register file writes at the rising edge. The destination is rt (bits 20:16) when `dst_sel`=0 and rd (bits 15:11) when `dst_sel`=1. The data is the ALU result when `wb_sel`=0 and the memory read data when `wb_sel`=1.
- R11: Register 0 always reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional program counter write |
| pc_wr_cond | input | 1 | Program counter write when the ALU result is zero |
| pc_src | input | 1 | Program counter source: 0 ALU result, 1 branch destination |
| tgt_wr | input | 1 | Branch destination register load enable |
| addr_sel | input | 1 | Memory read address: 0 program counter, 1 ALU result |
| mem_wr | input | 1 | Memory write enable |
| ir_wr | input | 1 | Instruction register load enable |
| dst_sel | input | 1 | Register destination: 0 rt, 1 rd |
| rf_wr | input | 1 | Register file write enable |
| a_sel | input | 1 | ALU operand A select |
| b_sel | input | 2 | ALU operand B select |
| alu_op | input | 2 | ALU operation select |
| ext_sign | input | 1 | 1 sign-extends, 0 zero-extends the immediate |
| wb_sel | input | 1 | Register write data: 0 ALU result, 1 memory data |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Instruction register |
| tgt_o | output | 32 | Branch destination register |
| alu_o | output | 32 | ALU result |
| zero_o | output | 1 | ALU result equals zero |
| mem_rdata_o | output | 32 | Memory read data |

## Verification
Register-register arithmetic is tried with operand pairs loaded from memory. The pairs separate signed from unsigned comparison, show carry and borrow wrap-around, and show that AND differs from OR on overlapping bit patterns. Immediate work uses an offset with the top bit set and a negative base offset, so sign extension is told apart from zero extension. Branches are run three ways: taken forward, not taken, and taken backward, which separates the conditional write, the destination register and the PC source select. A store followed by a load of the same word, and writes to register 0, show where data actually lands.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_OR    = 2'b10,
    ALU_FUNCT = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    BSRC_FOUR   = 2'b00,
    BSRC_REGB   = 2'b01,
    BSRC_IMM_X4 = 2'b10,
    BSRC_IMM    = 2'b11
  } bsrc_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [5:0]   funct,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] sum, diff, slt;

  assign sum  = a + b;
  assign diff = a - b;
  assign slt  = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};

  always_comb begin
    y = '0;
    unique case (alu_op_e'(op))
      ALU_ADD: y = sum;
      ALU_SUB: y = diff;
      ALU_OR:  y = a | b;
      ALU_FUNCT: begin
        case (funct)
          FN_ADD:  y = sum;
          FN_SUB:  y = diff;
          FN_AND:  y = a & b;
          FN_OR:   y = a | b;
          FN_SLT:  y = slt;
          default: y = '0;
        endcase
      end
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/mcdp_mem.sv
module mcdp_mem #(
  parameter int W     = 32,
  parameter int WORDS = 256,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end

  assign rdata = store[ridx];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcdp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic              pc_src,
  input  logic              tgt_wr,
  input  logic              addr_sel,
  input  logic              mem_wr,
  input  logic              ir_wr,
  input  logic              dst_sel,
  input  logic              rf_wr,
  input  logic              a_sel,
  input  logic [1:0]        b_sel,
  input  logic [1:0]        alu_op,
  input  logic              ext_sign,
  input  logic              wb_sel,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] tgt_o,
  output logic [DATA_W-1:0] alu_o,
  output logic              zero_o,
  output logic [DATA_W-1:0] mem_rdata_o
);

  localparam int NUM_REGS = 32;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int IDX_W    = $clog2(MEM_WORDS);
  localparam int IMM_W    = 16;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;

  logic [DATA_W-1:0] pc_q, ir_q, tgt_q;
  logic [DATA_W-1:0] rf_a, rf_b, op_a, op_b, alu_y, mem_q, ext_imm, wr_data;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, wr_reg;
  logic [IMM_W-1:0]  f_imm;
  logic              alu_zero, pc_load;
  logic [IDX_W-1:0]  rd_idx, wr_idx;

  assign f_rs  = ir_q[RS_LSB +: REG_AW];
  assign f_rt  = ir_q[RT_LSB +: REG_AW];
  assign f_rd  = ir_q[RD_LSB +: REG_AW];
  assign f_imm = ir_q[IMM_W-1:0];

  assign ext_imm = {{(DATA_W-IMM_W){ext_sign & f_imm[IMM_W-1]}}, f_imm};

  assign op_a = a_sel ? rf_a : pc_q;

  always_comb begin
    unique case (bsrc_e'(b_sel))
      BSRC_FOUR:   op_b = DATA_W'(4);
      BSRC_REGB:   op_b = rf_b;
      BSRC_IMM_X4: op_b = {ext_imm[DATA_W-3:0], 2'b00};
      BSRC_IMM:    op_b = ext_imm;
      default:     op_b = ext_imm;
    endcase
  end

  mcdp_alu #(.W(DATA_W)) u_alu (
    .op    (alu_op),
    .funct (ir_q[5:0]),
    .a     (op_a),
    .b     (op_b),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  assign rd_idx = addr_sel ? alu_y[IDX_W+1:2] : pc_q[IDX_W+1:2];
  assign wr_idx = alu_y[IDX_W+1:2];

  mcdp_mem #(.W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_wr),
    .widx  (wr_idx),
    .wdata (rf_b),
    .ridx  (rd_idx),
    .rdata (mem_q)
  );

  assign wr_reg  = dst_sel ? f_rd : f_rt;
  assign wr_data = wb_sel ? mem_q : alu_y;

  mcdp_regfile #(.W(DATA_W), .NREG(NUM_REGS)) u_rf (
    .clk     (clk),
    .we      (rf_wr),
    .waddr   (wr_reg),
    .wdata   (wr_data),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      tgt_q <= '0;
    end else begin
      if (pc_load) pc_q  <= pc_src ? tgt_q : alu_y;
      if (ir_wr)   ir_q  <= mem_q;
      if (tgt_wr)  tgt_q <= alu_y;
    end
  end

  assign pc_o        = pc_q;
  assign ir_o        = ir_q;
  assign tgt_o       = tgt_q;
  assign alu_o       = alu_y;
  assign zero_o      = alu_zero;
  assign mem_rdata_o = mem_q;

endmodule

// File: rtl/mcdp_checker.sv
module mcdp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pc_wr,
  input logic              pc_wr_cond,
  input logic              pc_src,
  input logic              tgt_wr,
  input logic              ir_wr,
  input logic [DATA_W-1:0] pc_o,
  input logic [DATA_W-1:0] ir_o,
  input logic [DATA_W-1:0] tgt_o,
  input logic [DATA_W-1:0] alu_o,
  input logic              zero_o,
  input logic [DATA_W-1:0] mem_rdata_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && ir_o == '0 && tgt_o == '0)); // R1

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !(pc_wr_cond && zero_o)) |=> $stable(pc_o)); // R6

  AST_PC_FROM_ALU: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && !pc_src) |=> (pc_o == $past(alu_o))); // R6

  AST_PC_FROM_TGT: assert property (@(posedge clk) disable iff (rst)
    ((pc_wr || (pc_wr_cond && zero_o)) && pc_src) |=> (pc_o == $past(tgt_o))); // R6

  AST_TGT_LOAD: assert property (@(posedge clk) disable iff (rst)
    tgt_wr |=> (tgt_o == $past(alu_o))); // R7

  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tgt_wr |=> $stable(tgt_o)); // R7

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (ir_o == $past(mem_rdata_o))); // R8

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(ir_o)); // R8

endmodule

bind mc_datapath mcdp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc_wr       (pc_wr),
  .pc_wr_cond  (pc_wr_cond),
  .pc_src      (pc_src),
  .tgt_wr      (tgt_wr),
  .ir_wr       (ir_wr),
  .pc_o        (pc_o),
  .ir_o        (ir_o),
  .tgt_o       (tgt_o),
  .alu_o       (alu_o),
  .zero_o      (zero_o),
  .mem_rdata_o (mem_rdata_o)
);

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  import mcdp_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{FN_ADD, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    '{FN_SUB, 32'h0000_0033, 32'h0000_0033, 32'h0000_0000},
    '{FN_AND, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0},
    '{FN_OR,  32'h1200_0034, 32'h0000_5600, 32'h1200_5634},
    '{FN_SLT, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    '{FN_SLT, 32'h0000_0005, 32'hFFFF_FFFE, 32'h0000_0000},
    '{FN_ADD, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    '{6'h3F,  32'h0000_0009, 32'h0000_0004, 32'h0000_0000},
    '{FN_SUB, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0;
  logic rst;
  logic pc_wr, pc_wr_cond, pc_src, tgt_wr, addr_sel, mem_wr, ir_wr;
  logic dst_sel, rf_wr, a_sel, ext_sign, wb_sel;
  logic [1:0] b_sel, alu_op;
  logic [31:0] pc_o, ir_o, tgt_o, alu_o, mem_rdata_o;
  logic zero_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] epc;
  logic [31:0] etgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_datapath dut (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .tgt_wr(tgt_wr), .addr_sel(addr_sel), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .dst_sel(dst_sel), .rf_wr(rf_wr), .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op),
    .ext_sign(ext_sign), .wb_sel(wb_sel), .pc_o(pc_o), .ir_o(ir_o), .tgt_o(tgt_o),
    .alu_o(alu_o), .zero_o(zero_o), .mem_rdata_o(mem_rdata_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic clr();
    pc_wr = 0; pc_wr_cond = 0; pc_src = 0; tgt_wr = 0; addr_sel = 0; mem_wr = 0;
    ir_wr = 0; dst_sel = 0; rf_wr = 0; a_sel = 0; ext_sign = 0; wb_sel = 0;
    b_sel = BSRC_FOUR; alu_op = ALU_ADD;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [31:0] addr, input logic [31:0] word);
    dut.u_mem.store[addr[9:2]] = word;
  endtask

  task automatic do_fetch(input logic [31:0] ins);
    put(epc, ins);
    clr(); pc_wr = 1; ir_wr = 1;
    tick();
    epc = epc + 32'd4;
    chk("R6 fetch pc+4", pc_o, epc);
    chk("R8 ir load", ir_o, ins);
  endtask

  task automatic do_decode(input logic [31:0] ins);
    clr(); tgt_wr = 1; ext_sign = 1; b_sel = BSRC_IMM_X4;
    tick();
    etgt = epc + {{14{ins[15]}}, ins[15:0], 2'b00};
    chk("R7 R2 target from pc", tgt_o, etgt);
    chk("R8 ir hold", ir_o, ins);
  endtask

  task automatic do_lw(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] imm,
                       input logic [31:0] eaddr, input logic [31:0] edata);
    logic [31:0] ins;
    ins = {6'h23, base, rt, imm};
    do_fetch(ins);
    do_decode(ins);
    clr(); a_sel = 1; b_sel = BSRC_IMM; ext_sign = 1;
    #1 chk("R3 load address", alu_o, eaddr);
    tick();
    addr_sel = 1;
    #1 chk("R9 load data", mem_rdata_o, edata);
    tick();
    rf_wr = 1; wb_sel = 1; dst_sel = 0;
    tick();
  endtask

  task automatic do_sw(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] imm,
                       input logic [31:0] eaddr);
    logic [31:0] ins;
    ins = {6'h2B, base, rt, imm};
    do_fetch(ins);
    do_decode(ins);
    clr(); a_sel = 1; b_sel = BSRC_IMM; ext_sign = 1;
    #1 chk("R9 store address", alu_o, eaddr);
    tick();
    mem_wr = 1;
    tick();
  endtask

  task automatic do_rtype(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                          input logic [5:0] fn, input logic [31:0] exp, input string tag);
    logic [31:0] ins;
    logic [31:0] pc_before;
    ins = {6'h00, rs, rt, rd, 5'h00, fn};
    do_fetch(ins);
    do_decode(ins);
    clr(); a_sel = 1; b_sel = BSRC_REGB; alu_op = ALU_FUNCT; dst_sel = 1;
    #1;
    chk(tag, alu_o, exp);
    chk("R5 zero flag", {31'b0, zero_o}, {31'b0, exp == 32'h0});
    pc_before = pc_o;
    tick();
    chk("R6 pc hold without write", pc_o, pc_before);
    rf_wr = 1;
    tick();
  endtask

  task automatic do_ori(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm,
                        input logic [31:0] exp);
    logic [31:0] ins;
    ins = {6'h0D, rs, rt, imm};
    do_fetch(ins);
    do_decode(ins);
    clr(); a_sel = 1; b_sel = BSRC_IMM; alu_op = ALU_OR; ext_sign = 0;
    #1 chk("R3 R4 or with zero-extended imm", alu_o, exp);
    tick();
    rf_wr = 1; dst_sel = 0;
    tick();
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off,
                        input bit taken);
    logic [31:0] ins;
    logic [31:0] held;
    ins = {6'h04, rs, rt, off};
    do_fetch(ins);
    do_decode(ins);
    held = etgt;
    clr(); a_sel = 1; b_sel = BSRC_REGB; alu_op = ALU_SUB; pc_wr_cond = 1; pc_src = 1;
    tick();
    if (taken) epc = held;
    chk(taken ? "R6 branch taken" : "R6 branch not taken", pc_o, epc);
    chk("R7 target hold", tgt_o, held);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    clr();
    rst = 1;
    epc = 32'h0;
    tick(); tick(); tick();
    chk("R1 reset pc", pc_o, 32'h0);
    chk("R1 reset ir", ir_o, 32'h0);
    chk("R1 reset target", tgt_o, 32'h0);
    rst = 0;

    for (int i = 0; i < NVEC; i++) begin
      put(32'h300, VEC[i].a);
      put(32'h304, VEC[i].b);
      do_lw(5'd1, 5'd0, 16'h0300, 32'h300, VEC[i].a);
      do_lw(5'd2, 5'd0, 16'h0304, 32'h304, VEC[i].b);
      do_rtype(5'd1, 5'd2, 5'd3, VEC[i].fn, VEC[i].exp, "R4 funct result");
    end
    // R10: rd of the last vector holds its result
    do_rtype(5'd3, 5'd0, 5'd10, FN_OR, VEC[NVEC-1].exp, "R10 rd written");

    do_ori(5'd0, 5'd4, 16'h8001, 32'h0000_8001);
    do_rtype(5'd4, 5'd0, 5'd13, FN_ADD, 32'h0000_8001, "R10 rt written by immediate op");
    do_sw(5'd4, 5'd0, 16'h0310, 32'h310);
    do_lw(5'd5, 5'd0, 16'h0310, 32'h310, 32'h0000_8001);
    do_ori(5'd0, 5'd7, 16'h0320, 32'h0000_0320);
    do_lw(5'd8, 5'd7, 16'hFFF0, 32'h310, 32'h0000_8001);
    do_rtype(5'd8, 5'd0, 5'd9, FN_ADD, 32'h0000_8001, "R10 load write-back to rt");

    // R11: writes to register 0 are dropped
    do_ori(5'd0, 5'd0, 16'h1234, 32'h0000_1234);
    do_rtype(5'd0, 5'd0, 5'd11, FN_OR, 32'h0, "R11 register 0 reads zero");

    do_beq(5'd4, 5'd4, 16'd3, 1'b1);
    do_beq(5'd4, 5'd0, 16'd5, 1'b0);
    do_beq(5'd0, 5'd0, 16'hFFFE, 1'b1);

    // R1: reset from a non-zero state
    clr(); rst = 1;
    tick();
    chk("R1 mid-run reset pc", pc_o, 32'h0);
    chk("R1 mid-run reset ir", ir_o, 32'h0);
    chk("R1 mid-run reset target", tgt_o, 32'h0);
    rst = 0;
    epc = 32'h0;
    do_ori(5'd0, 5'd14, 16'h0042, 32'h0000_0042);

    summary();
  end

endmodule